// File: doc/BRIEF.md
# Multi-Mode Up/Down Timer/Counter

This block is a general-purpose counter of configurable width (16 bits by default) for a data-acquisition datapath. It has an external event clock, a gate and a hardware direction input, all asynchronous to the system clock and brought into its domain through synchronizer chains. A two-bit mode field picks what the shared count register does after a start command.

In the two measurement modes the register counts event-clock rising edges, up or down. In the two generation modes it serves as the phase counter for a pulse whose delay and width are set in event-clock periods. Software can preset the count at any time and read the live value on `cnt_out`.

The generation modes are one-shot armed. Only the first active gate edge after a start is taken. Later gate edges do nothing until the start command is given again.

Top module: `updn_timer_counter`

## Requirements
- R1: After a synchronous reset `cnt_out` is 0 and `pulse_out`, `done` and `ovf` are 0.
- R2: A cycle with `ld_en` high makes `cnt_out` equal `ld_val` on the next cycle, taking precedence over any counting in that cycle.
- R3: With `cfg_mode` = 0 (event counting), after `start` each rising edge of `ev_clk_in` steps the count by one while the gate is active (gate active means `gate_in` equals `cfg_gate_pol`). Edges seen while the gate is inactive, or before any `start`, leave the count unchanged.
- R4: The direction is `updn_in` (1 = up) when `cfg_dir_hw` is 1, and `cfg_dir_up` (1 = up) otherwise.
- R5: The count wraps modulo 2^16, from 0xFFFF to 0x0000 going up and from 0x0000 to 0xFFFF going down. A wrap sets `ovf`, which stays set until the next `start`.
- R6: With `cfg_mode` = 1 (pulse-width), the count steps on event-clock rising edges while the gate is active. On the gate's active-to-inactive edge the count freezes and `done` rises. Later event-clock edges do not change the count.
- R7: With `cfg_mode` = 2 (single pulse), after the active gate edge `pulse_out` rises on the D-th event-clock rising edge (D = `dly_val`). It stays high for W edges (W = `wid_val`), then falls, and `done` rises.
- R8: A `dly_val` or `wid_val` of zero acts as one event-clock period.
- R9: With `cfg_mode` = 3 (continuous), pulses repeat after the first active gate edge: high for W edges, then low for D edges, and so on. `done` stays 0.
- R10: In modes 2 and 3, gate edges after the trigger have no effect. A new `start` clears `done`, `ovf` and `pulse_out` and re-arms the counter for one more trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_clk_in | input | 1 | Asynchronous event clock; its rising edges are counted |
| gate_in | input | 1 | Asynchronous gate / trigger input |
| updn_in | input | 1 | Asynchronous hardware direction, 1 = up |
| cfg_mode | input | 2 | 0 event, 1 pulse-width, 2 single pulse, 3 continuous |
| cfg_gate_pol | input | 1 | Gate level that counts as active |
| cfg_dir_hw | input | 1 | 1 selects `updn_in` as the direction source |
| cfg_dir_up | input | 1 | Software direction, 1 = up |
| ld_en | input | 1 | Preset strobe |
| ld_val | input | 16 | Preset value |
| dly_val | input | 16 | Delay / low time in event-clock periods |
| wid_val | input | 16 | High time in event-clock periods |
| start | input | 1 | Start / re-arm strobe |
| cnt_out | output | 16 | Live count |
| pulse_out | output | 1 | Generated pulse |
| done | output | 1 | Measurement or single pulse finished |
| ovf | output | 1 | Sticky wrap flag |

## Verification
An edge on `ev_clk_in` or `gate_in` passes two synchronizer flops and is then used by the registered engine. Its effect on `cnt_out`, `pulse_out` or `done` is therefore due on the third system-clock edge after the input changes. `ld_en` and `start` act on the very next edge. The bench drives every event-clock period as four system cycles high and four low, and waits six cycles after each gate change. Every sample falls on a falling edge of `clk`, several cycles after the result is due and before the next stimulus, so no check depends on the exact pipeline depth.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    MODE_EVENT  = 2'd0,
    MODE_PWIDTH = 2'd1,
    MODE_SINGLE = 2'd2,
    MODE_CONT   = 2'd3
  } tc_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RUN,
    PH_ARMED,
    PH_DELAY,
    PH_HIGH,
    PH_FIN
  } tc_phase_e;
endpackage

// File: rtl/tc_input_sync.sv
module tc_input_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] chain [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/tc_engine.sv
module tc_engine
  import tc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clk_rise,
  input  logic         gate_act,
  input  logic         gate_on,
  input  logic         gate_off,
  input  logic         dir_up,
  input  logic [1:0]   mode,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] dly_val,
  input  logic [W-1:0] wid_val,
  input  logic         start,
  output logic [W-1:0] cnt,
  output logic         pulse,
  output logic         done,
  output logic         ovf
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  tc_phase_e    phase;
  logic [W-1:0] dly_eff, wid_eff;
  logic         measuring;

  assign dly_eff   = (dly_val == '0) ? ONE : dly_val;
  assign wid_eff   = (wid_val == '0) ? ONE : wid_val;
  assign measuring = (mode == MODE_EVENT) || (mode == MODE_PWIDTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      pulse <= 1'b0;
      done  <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (start) begin
        done  <= 1'b0;
        ovf   <= 1'b0;
        pulse <= 1'b0;
        phase <= measuring ? PH_RUN : PH_ARMED;
      end else begin
        unique case (phase)
          PH_RUN: begin
            if (mode == MODE_PWIDTH && gate_off) begin
              phase <= PH_FIN;
              done  <= 1'b1;
            end else if (gate_act && clk_rise) begin
              if (dir_up) begin
                cnt <= cnt + ONE;
                if (cnt == ALL1) ovf <= 1'b1;
              end else begin
                cnt <= cnt - ONE;
                if (cnt == '0) ovf <= 1'b1;
              end
            end
          end
          PH_ARMED: begin
            if (gate_on) begin
              phase <= PH_DELAY;
              cnt   <= dly_eff;
            end
          end
          PH_DELAY: begin
            if (clk_rise) begin
              if (cnt <= ONE) begin
                phase <= PH_HIGH;
                pulse <= 1'b1;
                cnt   <= wid_eff;
              end else begin
                cnt <= cnt - ONE;
              end
            end
          end
          PH_HIGH: begin
            if (clk_rise) begin
              if (cnt <= ONE) begin
                pulse <= 1'b0;
                if (mode == MODE_CONT) begin
                  phase <= PH_DELAY;
                  cnt   <= dly_eff;
                end else begin
                  phase <= PH_FIN;
                  done  <= 1'b1;
                end
              end else begin
                cnt <= cnt - ONE;
              end
            end
          end
          default: ;
        endcase
      end
      if (ld_en) cnt <= ld_val;
    end
  end
endmodule

// File: rtl/updn_timer_counter.sv
module updn_timer_counter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_clk_in,
  input  logic             gate_in,
  input  logic             updn_in,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_gate_pol,
  input  logic             cfg_dir_hw,
  input  logic             cfg_dir_up,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] dly_val,
  input  logic [CNT_W-1:0] wid_val,
  input  logic             start,
  output logic [CNT_W-1:0] cnt_out,
  output logic             pulse_out,
  output logic             done,
  output logic             ovf
);
  localparam int NIN   = 3;
  localparam int I_CLK = 0;
  localparam int I_GT  = 1;
  localparam int I_DIR = 2;

  logic [NIN-1:0] s_lvl, s_rise, s_fall;
  logic           gate_act, gate_on, gate_off, dir_up;

  tc_input_sync #(.N(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({updn_in, gate_in, ev_clk_in}),
    .lvl  (s_lvl),
    .rise (s_rise),
    .fall (s_fall)
  );

  assign gate_act = (s_lvl[I_GT] == cfg_gate_pol);
  assign gate_on  = cfg_gate_pol ? s_rise[I_GT] : s_fall[I_GT];
  assign gate_off = cfg_gate_pol ? s_fall[I_GT] : s_rise[I_GT];
  assign dir_up   = cfg_dir_hw ? s_lvl[I_DIR] : cfg_dir_up;

  tc_engine #(.W(CNT_W)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .clk_rise (s_rise[I_CLK]),
    .gate_act (gate_act),
    .gate_on  (gate_on),
    .gate_off (gate_off),
    .dir_up   (dir_up),
    .mode     (cfg_mode),
    .ld_en    (ld_en),
    .ld_val   (ld_val),
    .dly_val  (dly_val),
    .wid_val  (wid_val),
    .start    (start),
    .cnt      (cnt_out),
    .pulse    (pulse_out),
    .done     (done),
    .ovf      (ovf)
  );
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cfg_mode,
  input logic             ld_en,
  input logic [CNT_W-1:0] ld_val,
  input logic             start,
  input logic [CNT_W-1:0] cnt_out,
  input logic             pulse_out,
  input logic             done,
  input logic             ovf
);
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> cnt_out == $past(ld_val));

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (ovf && !start) |=> ovf);

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && !ovf && !pulse_out));

  assert_frozen_width_R6: assert property (@(posedge clk) disable iff (rst)
    (done && cfg_mode == 2'd1 && !ld_en && !start) |=> $stable(cnt_out));

  assert_done_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(cfg_mode) == 2'd1 || $past(cfg_mode) == 2'd2));

  assert_pulse_gen_only_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_out) |-> ($past(cfg_mode) >= 2'd2));
endmodule

bind updn_timer_counter tc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_mode  (cfg_mode),
  .ld_en     (ld_en),
  .ld_val    (ld_val),
  .start     (start),
  .cnt_out   (cnt_out),
  .pulse_out (pulse_out),
  .done      (done),
  .ovf       (ovf)
);

// File: tb/updn_timer_counter_test.sv
module updn_timer_counter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_clk_in = 1'b0, gate_in = 1'b0, updn_in = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_gate_pol = 1'b1, cfg_dir_hw = 1'b0, cfg_dir_up = 1'b1;
  logic        ld_en = 1'b0, start = 1'b0;
  logic [15:0] ld_val = '0, dly_val = '0, wid_val = '0;
  logic [15:0] cnt_out;
  logic        pulse_out, done, ovf;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  updn_timer_counter uut (
    .clk(clk), .rst(rst), .ev_clk_in(ev_clk_in), .gate_in(gate_in),
    .updn_in(updn_in), .cfg_mode(cfg_mode), .cfg_gate_pol(cfg_gate_pol),
    .cfg_dir_hw(cfg_dir_hw), .cfg_dir_up(cfg_dir_up), .ld_en(ld_en),
    .ld_val(ld_val), .dly_val(dly_val), .wid_val(wid_val), .start(start),
    .cnt_out(cnt_out), .pulse_out(pulse_out), .done(done), .ovf(ovf)
  );

  // {preset[42:27], up[26], gate[25], edges[24:17], expected[16:1], ovf[0]}
  localparam logic [42:0] VEC [5] = '{
    {16'h0000, 1'b1, 1'b1, 8'd5, 16'h0005, 1'b0},
    {16'hFFFE, 1'b1, 1'b1, 8'd3, 16'h0001, 1'b1},
    {16'h0010, 1'b0, 1'b1, 8'd3, 16'h000D, 1'b0},
    {16'h1234, 1'b1, 1'b0, 8'd4, 16'h1234, 1'b0},
    {16'h0001, 1'b0, 1'b1, 8'd2, 16'hFFFF, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ev_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      ev_clk_in = 1'b1; cyc(4);
      ev_clk_in = 1'b0; cyc(4);
    end
  endtask

  task automatic do_start();
    start = 1'b1; cyc(1); start = 1'b0; cyc(1);
  endtask

  task automatic do_load(input logic [15:0] v);
    ld_val = v; ld_en = 1'b1; cyc(1); ld_en = 1'b0; cyc(1);
  endtask

  task automatic gate_set(input logic v);
    gate_in = v; cyc(6);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst = 1'b0; cyc(1);
    // R1 reset state
    check("R1 cnt", cnt_out, 16'h0);
    check("R1 flags", {13'b0, pulse_out, done, ovf}, 16'h0);

    // R3: edges before any start do nothing
    gate_set(1'b1);
    ev_pulse(3);
    check("R3 no start", cnt_out, 16'h0);

    // R3 R4 R5 table walk in event mode
    foreach (VEC[i]) begin
      cfg_dir_up = VEC[i][26];
      gate_set(VEC[i][25]);
      do_load(VEC[i][42:27]);
      check("R2 preset", cnt_out, VEC[i][42:27]);
      do_start();
      ev_pulse(int'(VEC[i][24:17]));
      check("R3 count", cnt_out, VEC[i][16:1]);
      check("R5 ovf", {15'b0, ovf}, {15'b0, VEC[i][0]});
    end

    // R4 hardware direction overrides software
    cfg_dir_hw = 1'b1; cfg_dir_up = 1'b1; updn_in = 1'b0; gate_set(1'b1);
    do_load(16'd10); do_start(); ev_pulse(2);
    check("R4 hw down", cnt_out, 16'd8);
    updn_in = 1'b1; cyc(4); ev_pulse(3);
    check("R4 hw up", cnt_out, 16'd11);
    cfg_dir_hw = 1'b0;

    // R2 preset while running
    do_load(16'h0055); cyc(3);
    check("R2 running preset", cnt_out, 16'h0055);

    // R6 pulse-width, active-low gate
    cfg_mode = 2'd1; cfg_gate_pol = 1'b0; gate_set(1'b1);
    do_load(16'h0); do_start();
    gate_set(1'b0); ev_pulse(3); gate_set(1'b1);
    check("R6 width", cnt_out, 16'd3);
    check("R6 done", {15'b0, done}, 16'd1);
    ev_pulse(2);
    check("R6 frozen", cnt_out, 16'd3);
    cfg_gate_pol = 1'b1;

    // R7 single pulse, delay 3 width 2
    cfg_mode = 2'd2; dly_val = 16'd3; wid_val = 16'd2; gate_set(1'b0);
    do_start();
    check("R10 start clears done", {15'b0, done}, 16'd0);
    gate_set(1'b1);
    for (int k = 1; k <= 5; k++) begin
      ev_pulse(1);
      check($sformatf("R7 edge %0d", k), {15'b0, pulse_out}, {15'b0, (k == 3 || k == 4)});
    end
    check("R7 done", {15'b0, done}, 16'd1);

    // R10 later gate edges ignored, then re-arm
    gate_set(1'b0); gate_set(1'b1); ev_pulse(4);
    check("R10 ignored", {15'b0, pulse_out}, 16'd0);
    check("R10 done held", {15'b0, done}, 16'd1);
    do_start(); gate_set(1'b0); gate_set(1'b1); ev_pulse(3);
    check("R10 rearmed", {15'b0, pulse_out}, 16'd1);
    ev_pulse(2);

    // R8 zero delay and width
    dly_val = 16'd0; wid_val = 16'd0; gate_set(1'b0); do_start(); gate_set(1'b1);
    ev_pulse(1);
    check("R8 zero delay", {15'b0, pulse_out}, 16'd1);
    ev_pulse(1);
    check("R8 zero width", {15'b0, pulse_out}, 16'd0);
    check("R8 done", {15'b0, done}, 16'd1);

    // R9 continuous, low 1 high 2
    cfg_mode = 2'd3; dly_val = 16'd1; wid_val = 16'd2; gate_set(1'b0);
    do_start(); gate_set(1'b1);
    for (int k = 1; k <= 7; k++) begin
      int pos;
      pos = (k - 1) % 3;
      ev_pulse(1);
      check($sformatf("R9 edge %0d", k), {15'b0, pulse_out}, {15'b0, (pos >= 0 && pos < 2)});
    end
    check("R9 no done", {15'b0, done}, 16'd0);

    finish_run();
  end
endmodule